// File: doc/BRIEF.md
# Programmable LED Blink Controller

This block drives four general-purpose LEDs and two status LEDs from two 16-bit registers. Each LED has a 4-bit mode field. The field turns the LED off or on, or makes it blink at one of two rates. The two status LEDs have two more modes. In these modes the LED follows a live hardware indication: either a PLL-lock level or a stretched Ethernet-activity pulse.

Both blink rates come from one shared prescaler, so all LEDs blink in phase. A slow blink has four times the period of a fast blink. A short activity pulse is stretched into a fixed, visible on-time. A forced dark gap follows it, so that steady traffic reads as blinking rather than as a solid light. A register bridge outside this block drives a single-cycle write strobe with a register select, and reads through a combinational read mux.

Top module: `led_blink_ctrl`

## Requirements
- R1: The general-purpose register holds one 4-bit mode per LED: LED0 in bits 3..0, LED1 in 7..4, LED2 in 11..8 and LED3 in 15..12. A write with `wr_sel`=0 takes effect on the clock edge that samples `wr_en`.
- R2: General-purpose modes are 0x0 off, 0x1 on, 0x2 slow blink and 0x3 fast blink. Every value from 0x4 to 0xF drives the LED off.
- R3: The status register holds status LED0 in bits 3..0 and status LED1 in bits 7..4. Modes 0x0 to 0x3 behave as in R2. Mode 0x4 follows `pll_locked`, mode 0x5 shows the stretched activity of R8, and 0x6 to 0xF drive the LED off.
- R4: After reset the general-purpose register reads 0x0000 and the status register reads 0x0054. Status LED0 then shows lock and status LED1 shows activity.
- R5: Bits 15..8 of the status register always read zero, and writes to them have no effect.
- R6: `rd_data` returns the general-purpose register when `rd_sel`=0 and the status register when `rd_sel`=1, in the same cycle.
- R7: Count the clock edges since reset was released as m. The fast-blink level is ((m / FAST_HALF_CYC) mod 2) and the slow-blink level is ((m / FAST_HALF_CYC) mod 8) >= 4. Both start low.
- R8: An `eth_act` high sampled while the stretcher is idle lights the activity level for exactly ACT_ON_CYC cycles, starting after that edge. Further pulses during the on time do not extend it. A dark gap of ACT_OFF_CYC cycles follows, and pulses during the gap are ignored.
- R9: A write to one register leaves the other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_sel | input | 1 | Write target: 0 general-purpose, 1 status |
| wr_data | input | 16 | Write data |
| rd_sel | input | 1 | Read source: 0 general-purpose, 1 status |
| rd_data | output | 16 | Read data of the selected register |
| pll_locked | input | 1 | Live PLL lock indication |
| eth_act | input | 1 | Ethernet activity pulse |
| gp_led | output | 4 | General-purpose LED levels, bit n is LED n |
| st_led | output | 2 | Status LED levels |

## Verification
A corrupted register value shows on `rd_data` in the very next cycle, and on the LED pin of the affected nibble as soon as that mode's level differs. A prescaler or phase counter that is off by one edge shows as a blink transition one cycle early or late, at the first boundary where FAST_HALF_CYC divides the edge count. A stretcher in the wrong state shows on a status LED in activity mode as an on-time or gap of the wrong length. It also shows as a pulse that is accepted when it should be ignored, within ACT_ON_CYC plus ACT_OFF_CYC cycles. The bench models all of this from edge counts and compares every output on every cycle.

// File: rtl/led_pkg.sv
package led_pkg;

  localparam logic [3:0] MODE_OFF  = 4'h0;
  localparam logic [3:0] MODE_ON   = 4'h1;
  localparam logic [3:0] MODE_SLOW = 4'h2;
  localparam logic [3:0] MODE_FAST = 4'h3;
  localparam logic [3:0] MODE_LOCK = 4'h4;
  localparam logic [3:0] MODE_ACT  = 4'h5;

  typedef enum logic [1:0] {
    ACT_IDLE = 2'd0,
    ACT_LIT  = 2'd1,
    ACT_GAP  = 2'd2
  } act_state_t;

  // Level of one LED for a given mode; hw_ok enables the hardware-sourced modes.
  function automatic logic led_level(input logic [3:0] mode, input logic hw_ok,
                                     input logic slow, input logic fast,
                                     input logic lock, input logic act);
    logic lvl;
    lvl = 1'b0;
    unique case (mode)
      MODE_ON:   lvl = 1'b1;
      MODE_SLOW: lvl = slow;
      MODE_FAST: lvl = fast;
      MODE_LOCK: lvl = hw_ok & lock;
      MODE_ACT:  lvl = hw_ok & act;
      default:   lvl = 1'b0;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/led_timebase.sv
module led_timebase #(
  parameter int unsigned FAST_HALF_CYC = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic fast_blink,
  output logic slow_blink
);
  localparam int unsigned CW = (FAST_HALF_CYC > 1) ? $clog2(FAST_HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(FAST_HALF_CYC - 1);

  logic [CW-1:0] presc_q;
  logic [2:0]    phase_q;
  logic          half_tick;

  assign half_tick = (presc_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      phase_q <= '0;
    end else if (half_tick) begin
      presc_q <= '0;
      phase_q <= phase_q + 3'd1;
    end else begin
      presc_q <= presc_q + 1'b1;
    end
  end

  assign fast_blink = phase_q[0];
  assign slow_blink = phase_q[2];

  assert_phase_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |=> phase_q == $past(phase_q) + 3'd1);
  assert_phase_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !half_tick |=> $stable(phase_q));
endmodule

// File: rtl/led_act_stretch.sv
module led_act_stretch
  import led_pkg::*;
#(
  parameter int unsigned ACT_ON_CYC  = 10_000_000,
  parameter int unsigned ACT_OFF_CYC = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_in,
  output logic act_led
);
  localparam int unsigned MAXC = (ACT_ON_CYC > ACT_OFF_CYC) ? ACT_ON_CYC : ACT_OFF_CYC;
  localparam int unsigned CW   = (MAXC > 1) ? $clog2(MAXC) : 1;

  act_state_t    state_q;
  logic [CW-1:0] cnt_q;
  logic          cnt_done;

  assign cnt_done = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ACT_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ACT_IDLE: if (act_in) begin
          state_q <= ACT_LIT;
          cnt_q   <= CW'(ACT_ON_CYC - 1);
        end
        ACT_LIT: if (cnt_done) begin
          state_q <= ACT_GAP;
          cnt_q   <= CW'(ACT_OFF_CYC - 1);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        ACT_GAP: if (cnt_done) state_q <= ACT_IDLE;
                 else cnt_q <= cnt_q - 1'b1;
        default: state_q <= ACT_IDLE;
      endcase
    end
  end

  assign act_led = (state_q == ACT_LIT);

  assert_act_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_led) |-> $past(act_in));
  assert_act_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_led) |=> !act_led);
endmodule

// File: rtl/led_regs.sv
module led_regs #(
  parameter int unsigned REG_W = 16,
  parameter int unsigned ST_W  = 8,
  parameter logic [REG_W-1:0] GP_RST = '0,
  parameter logic [ST_W-1:0]  ST_RST = 8'h54
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [REG_W-1:0] rd_data,
  output logic [REG_W-1:0] gp_q,
  output logic [ST_W-1:0]  st_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gp_q <= GP_RST;
      st_q <= ST_RST;
    end else if (wr_en) begin
      if (wr_sel) st_q <= wr_data[ST_W-1:0];
      else        gp_q <= wr_data;
    end
  end

  assign rd_data = rd_sel ? {{(REG_W-ST_W){1'b0}}, st_q} : gp_q;

  assert_gp_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> gp_q == $past(wr_data));
  assert_gp_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> $stable(gp_q));
  assert_st_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> $stable(st_q));
endmodule

// File: rtl/led_blink_ctrl.sv
module led_blink_ctrl
  import led_pkg::*;
#(
  parameter int unsigned FAST_HALF_CYC = 50_000_000,
  parameter int unsigned ACT_ON_CYC    = 10_000_000,
  parameter int unsigned ACT_OFF_CYC   = 10_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [15:0] wr_data,
  input  logic        rd_sel,
  output logic [15:0] rd_data,
  input  logic        pll_locked,
  input  logic        eth_act,
  output logic [3:0]  gp_led,
  output logic [1:0]  st_led
);
  localparam int unsigned REG_W  = 16;
  localparam int unsigned NUM_GP = REG_W / 4;
  localparam int unsigned NUM_ST = 2;
  localparam int unsigned ST_W   = 4 * NUM_ST;

  logic              fast_blink, slow_blink, act_level;
  logic [REG_W-1:0]  gp_q;
  logic [ST_W-1:0]   st_q;

  led_timebase #(.FAST_HALF_CYC(FAST_HALF_CYC)) u_tb (
    .clk(clk), .rst_n(rst_n), .fast_blink(fast_blink), .slow_blink(slow_blink));

  led_act_stretch #(.ACT_ON_CYC(ACT_ON_CYC), .ACT_OFF_CYC(ACT_OFF_CYC)) u_act (
    .clk(clk), .rst_n(rst_n), .act_in(eth_act), .act_led(act_level));

  led_regs #(.REG_W(REG_W), .ST_W(ST_W), .GP_RST('0), .ST_RST(8'h54)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .gp_q(gp_q), .st_q(st_q));

  for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
    assign gp_led[g] = led_level(gp_q[4*g +: 4], 1'b0, slow_blink, fast_blink,
                                 pll_locked, act_level);
  end

  for (genvar s = 0; s < NUM_ST; s++) begin : g_st
    assign st_led[s] = led_level(st_q[4*s +: 4], 1'b1, slow_blink, fast_blink,
                                 pll_locked, act_level);
  end

  assert_lock_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[3:0] == MODE_LOCK) |-> st_led[0] == pll_locked);
  assert_gp_no_hw_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (gp_q[3:0] == MODE_LOCK) |-> !gp_led[0]);
endmodule

// File: tb/tb_led_blink_ctrl.sv
module tb_led_blink_ctrl;
  localparam int HALF = 5;
  localparam int ON_C = 7;
  localparam int OFF_C = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic pll_locked = 1'b0, eth_act = 1'b0;
  logic [15:0] rd_data;
  logic [3:0] gp_led;
  logic [1:0] st_led;

  always #2.5 clk = ~clk;

  led_blink_ctrl #(.FAST_HALF_CYC(HALF), .ACT_ON_CYC(ON_C), .ACT_OFF_CYC(OFF_C)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .pll_locked(pll_locked), .eth_act(eth_act),
    .gp_led(gp_led), .st_led(st_led));

  int n_chk = 0, n_bad = 0;
  string tag = "R4";

  // Reference model state
  int edges = 0;
  int on_left = 0, gap_left = 0;
  logic [15:0] m_gp = 16'h0000;
  logic [7:0]  m_st = 8'h54;

  always @(posedge clk) begin
    if (!rst_n) begin
      edges = 0; on_left = 0; gap_left = 0; m_gp = 16'h0000; m_st = 8'h54;
    end else begin
      edges++;
      if (on_left > 0) begin
        on_left--;
        if (on_left == 0) gap_left = OFF_C;
      end else if (gap_left > 0) gap_left--;
      else if (eth_act) on_left = ON_C;
      if (wr_en && wr_sel) m_st = wr_data[7:0];
      if (wr_en && !wr_sel) m_gp = wr_data;
    end
  end

  function automatic bit ref_level(input int mode, input bit status);
    int ph;
    ph = (edges / HALF) % 8;
    if (mode == 1) return 1;
    if (mode == 2) return ph >= 4;
    if (mode == 3) return (ph % 2) == 1;
    if (status && mode == 4) return pll_locked;
    if (status && mode == 5) return on_left > 0;
    return 0;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at edge %0d", req, act, exp, edges);
    end
  endtask

  task automatic compare_all();
    logic [3:0] eg;
    logic [1:0] es;
    for (int i = 0; i < 4; i++) eg[i] = ref_level(int'(m_gp[4*i +: 4]), 1'b0);
    for (int i = 0; i < 2; i++) es[i] = ref_level(int'(m_st[4*i +: 4]), 1'b1);
    check({tag, " gp_led R2"}, {12'h0, gp_led}, {12'h0, eg});
    check({tag, " st_led R3"}, {14'h0, st_led}, {14'h0, es});
    check({tag, " rd_data R6"}, rd_data, rd_sel ? {8'h00, m_st} : m_gp);
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
      compare_all();
      wr_en = 1'b0;
    end
  endtask

  task automatic wr(input bit sel, input logic [15:0] d);
    wr_sel = sel; wr_data = d; wr_en = 1'b1;
    cyc(1);
  endtask

  initial begin
    #20000;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #11 rst_n = 1'b1;
    // R4: reset values
    tag = "R4";
    rd_sel = 1'b0; #1 check("R4 gp reset", rd_data, 16'h0000);
    rd_sel = 1'b1; #1 check("R4 st reset", rd_data, 16'h0054);
    cyc(3);
    // R7: blink phases on every general-purpose LED
    tag = "R7"; rd_sel = 1'b0;
    wr(1'b0, 16'h3232);
    cyc(45);
    // R1: nibble placement
    tag = "R1";
    wr(1'b0, 16'h3210);
    check("R1 nibble map", rd_data, 16'h3210);
    cyc(30);
    // R2: reserved and hardware codes give off on general-purpose LEDs
    tag = "R2"; pll_locked = 1'b1;
    wr(1'b0, 16'hF4A5);
    check("R2 reserved off", {12'h0, gp_led}, 16'h0000);
    cyc(10);
    // R3: status modes, lock following
    tag = "R3"; rd_sel = 1'b1;
    wr(1'b1, 16'h0014);
    for (int i = 0; i < 12; i++) begin
      pll_locked = (i % 3) != 0;
      cyc(1);
    end
    wr(1'b1, 16'h0023);
    cyc(20);
    wr(1'b1, 16'h0096);
    check("R3 reserved off", {14'h0, st_led}, 16'h0000);
    // R5: reserved upper bits
    tag = "R5";
    wr(1'b1, 16'hAB45);
    check("R5 upper zero", rd_data, 16'h0045);
    // R9: write one register, other holds
    tag = "R9";
    wr(1'b0, 16'h1111);
    check("R9 st kept", rd_data, 16'h0045);
    rd_sel = 1'b0;
    wr(1'b1, 16'h0055);
    check("R9 gp kept", rd_data, 16'h1111);
    // R8: activity stretcher under several pulse patterns
    tag = "R8"; rd_sel = 1'b1;
    eth_act = 1'b1; cyc(1); eth_act = 1'b0;
    cyc(3);
    check("R8 lit", {14'h0, st_led}, 16'h0003);
    cyc(20);
    for (int i = 0; i < 120; i++) begin
      eth_act = ((i * 7) % 11) < 3;
      cyc(1);
    end
    eth_act = 1'b1; cyc(40); eth_act = 1'b0;
    cyc(15);
    check("R8 idle dark", {14'h0, st_led}, 16'h0000);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule